// File: doc/BRIEF.md
# Page-Write Parallel EEPROM Emulator

This block models a byte-wide nonvolatile memory behind an asynchronous-style parallel bus. The bus pins are active-low chip-enable, output-enable and write-enable, plus an address and a byte of write data. All of them are sampled in the system clock domain. Writes do not reach the storage array at once. They collect in a page latch chosen by the upper address bits. A byte-load window timer restarts on every accepted write strobe. When the timer runs out, the latched page is committed during a self-timed programming period of fixed length. A cycle counter stands in for the cell programming. Only bytes that were loaded replace array contents, and no erase step is modelled.

Completion is reported through ordinary reads. While a page is open or being programmed, every read returns a status byte instead of array data. In that byte, bit 7 is the complement of bit 7 of the last byte loaded, bit 6 flips on each new read, and bits 5..0 read as zero. Software polls until it reads back the true data. The array is an inferred RAM. `ADDR_W` = 16 gives the full 65,536 x 8 organisation; the default is smaller so that elaboration stays light. A page holds 2^`PAGE_W` bytes, which is 128 by default.

Top module: `pagewrite_eeprom`

## Requirements
- R1: While reset is held, `dataOut` is 0x00 and no page is open.
- R2: `dataOutEn` is 1 exactly when `ceN`=0, `oeN`=0 and `weN`=1 in the same cycle, and is 0 for every other combination.
- R3: A read cycle starts on the first clock where `ceN`=0, `oeN`=0 and `weN`=1 hold after a clock where they did not. When no page is open, `dataOut` shows the array byte at `addr` from the clock edge that samples the read.
- R4: A write strobe is the first clock where `ceN`=0, `weN`=0 and `oeN`=1 hold. A single-byte write replaces the stored byte with the new value, for any old value, once programming ends.
- R5: All bytes of a full page loaded in one window, offsets 0 through 2^`PAGE_W`-1, are committed together.
- R6: Bytes of the page that were not loaded keep their earlier array contents after the commit.
- R7: While a page is open, a write strobe whose upper address bits (above bit `PAGE_W`-1) differ from the open page is discarded and does not restart the window.
- R8: The window restarts on each accepted strobe. A strobe up to `WINDOW_CYCLES` clocks after the previous one is still accepted, and programming begins `WINDOW_CYCLES` clocks after the last accepted strobe.
- R9: While a page is open or programming, a read returns bit 7 equal to the complement of bit 7 of the last loaded byte, and bits 5..0 equal to zero.
- R10: In that status mode, bit 6 of `dataOut` flips at each read start and holds otherwise.
- R11: Write strobes that arrive during programming are ignored and change no array byte.
- R12: Programming lasts max(`BUSY_CYCLES`, 2^`PAGE_W`) clocks. A read sampled on the last edge of that period still shows status, and the next read shows the stored data.
- R13: If one offset is written twice in a window, the later value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address; upper bits pick the page, lower `PAGE_W` bits the byte |
| dataIn | input | 8 | Write data from the bus |
| dataOut | output | 8 | Read data or status byte |
| dataOutEn | output | 1 | Drive enable for the data lines; 0 means high impedance |

## Verification
A wrong window count or programming length shows up in one precise way. Either a late write that should have been discarded reaches the array, or a read placed on the last edge of the busy period shows data instead of status. Both are visible within one read of the boundary. A bad page latch or valid mask is seen once the page is read back: a neighbour byte is clobbered, or one of a full page's 128 bytes is missing. A broken toggle or complement in the status path is visible on the first two status reads after any write.

// File: rtl/pagewrite_eeprom_pkg.sv
`timescale 1ns/1ps
package pagewrite_eeprom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } emuState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic openPage;    // capture the page of the first byte
    logic loadByte;    // write dataIn into the page latch
    logic progEn;      // commit walk is active this cycle
    logic clearPage;   // last programming cycle: drop the valid mask
    logic statusMode;  // reads return the status byte
    logic readStart;   // first cycle of a read
  } emuStrobes_t;

endpackage

// File: rtl/pagewrite_eeprom_ctrl.sv
`timescale 1ns/1ps
module pagewrite_eeprom_ctrl
  import pagewrite_eeprom_pkg::*;
#(
  parameter int PAGE_W        = 7,
  parameter int WINDOW_CYCLES = 64,
  parameter int BUSY_CYCLES   = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              pageMatch,
  output emuStrobes_t       strobes,
  output logic [PAGE_W-1:0] progOff
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PROG_LEN   = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES : PAGE_BYTES;
  localparam int TIMER_W    = $clog2(WINDOW_CYCLES + 1);
  localparam int CNT_W      = $clog2(PROG_LEN + 1);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(WINDOW_CYCLES - 1);
  localparam logic [CNT_W-1:0]   CNT_LAST   = CNT_W'(PROG_LEN - 1);
  localparam logic [CNT_W-1:0]   CNT_PAGE   = CNT_W'(PAGE_BYTES);

  emuState_t          state;
  logic [TIMER_W-1:0] timer;
  logic [CNT_W-1:0]   cnt;
  logic               wrPrev, rdPrev;
  logic               wrActive, rdActive, wrStart, rdStart;

  assign wrActive = !ceN && !weN && oeN;
  assign rdActive = !ceN && !oeN && weN;
  assign wrStart  = wrActive && !wrPrev;
  assign rdStart  = rdActive && !rdPrev;

  always_comb begin
    strobes.openPage   = (state == ST_IDLE) && wrStart;
    strobes.loadByte   = ((state == ST_IDLE) && wrStart) ||
                         ((state == ST_LOAD) && wrStart && pageMatch);
    strobes.progEn     = (state == ST_PROG) && (cnt < CNT_PAGE);
    strobes.clearPage  = (state == ST_PROG) && (cnt == CNT_LAST);
    strobes.statusMode = (state != ST_IDLE);
    strobes.readStart  = rdStart;
  end

  assign progOff = cnt[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      cnt    <= '0;
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= wrActive;
      rdPrev <= rdActive;
      case (state)
        ST_IDLE: begin
          if (wrStart) begin
            state <= ST_LOAD;
            timer <= '0;
          end
        end
        ST_LOAD: begin
          if (wrStart && pageMatch) begin
            timer <= '0;
          end else if (timer == TIMER_LAST) begin
            state <= ST_PROG;
            cnt   <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt == CNT_LAST) state <= ST_IDLE;
          else                 cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pagewrite_eeprom_dp.sv
`timescale 1ns/1ps
module pagewrite_eeprom_dp
  import pagewrite_eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  emuStrobes_t       strobes,
  input  logic [PAGE_W-1:0] progOff,
  output logic              pageMatch,
  output logic [7:0]        dataOut,
  output logic              dataOutEn
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BASE_W     = ADDR_W - PAGE_W;
  localparam int DEPTH      = 1 << ADDR_W;

  logic [7:0]            arrayMem [DEPTH];
  logic [7:0]            latchMem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validBits;
  logic [BASE_W-1:0]     pageReg;
  logic [PAGE_W-1:0]     byteOff;
  logic                  lastMsb, tglQ, tglNext;
  logic                  statusQ;
  logic [7:0]            statusByteQ, ramQ;

  assign byteOff   = addr[PAGE_W-1:0];
  assign pageMatch = (addr[ADDR_W-1:PAGE_W] == pageReg);
  assign tglNext   = tglQ ^ (strobes.readStart && strobes.statusMode);

  // page latch: plain storage, qualified by validBits
  always_ff @(posedge clk) begin
    if (strobes.loadByte) latchMem[byteOff] <= dataIn;
  end

  // array write port, one latched byte per programming cycle
  always_ff @(posedge clk) begin
    if (strobes.progEn && validBits[progOff])
      arrayMem[{pageReg, progOff}] <= latchMem[progOff];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits   <= '0;
      pageReg     <= '0;
      lastMsb     <= 1'b0;
      tglQ        <= 1'b0;
      statusQ     <= 1'b0;
      statusByteQ <= '0;
      ramQ        <= '0;
    end else begin
      ramQ        <= arrayMem[addr];
      tglQ        <= tglNext;
      statusQ     <= strobes.statusMode;
      statusByteQ <= {~lastMsb, tglNext, 6'b0};
      if (strobes.openPage) pageReg <= addr[ADDR_W-1:PAGE_W];
      if (strobes.loadByte) lastMsb <= dataIn[7];
      if (strobes.clearPage)     validBits          <= '0;
      else if (strobes.loadByte) validBits[byteOff] <= 1'b1;
    end
  end

  assign dataOut   = statusQ ? statusByteQ : ramQ;
  assign dataOutEn = !ceN && !oeN && weN;

endmodule

// File: rtl/pagewrite_eeprom.sv
`timescale 1ns/1ps
module pagewrite_eeprom
  import pagewrite_eeprom_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int PAGE_W        = 7,
  parameter int WINDOW_CYCLES = 64,
  parameter int BUSY_CYCLES   = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOutEn
);
  emuStrobes_t       strobes;
  logic [PAGE_W-1:0] progOff;
  logic              pageMatch;

  pagewrite_eeprom_ctrl #(
    .PAGE_W(PAGE_W), .WINDOW_CYCLES(WINDOW_CYCLES), .BUSY_CYCLES(BUSY_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pageMatch(pageMatch), .strobes(strobes), .progOff(progOff)
  );

  pagewrite_eeprom_dp #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .strobes(strobes), .progOff(progOff),
    .pageMatch(pageMatch), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

endmodule

// File: rtl/pagewrite_eeprom_chk.sv
`timescale 1ns/1ps
module pagewrite_eeprom_chk
  import pagewrite_eeprom_pkg::*;
#(
  parameter int PAGE_W        = 7,
  parameter int WINDOW_CYCLES = 64,
  parameter int BUSY_CYCLES   = 256
) (
  input logic        clk,
  input logic        rstN,
  input logic        ceN,
  input logic        oeN,
  input logic        weN,
  input logic [7:0]  dataOut,
  input logic        dataOutEn,
  input emuStrobes_t strobes
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PROG_LEN   = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES : PAGE_BYTES;

  logic [15:0] sinceLoad, progCount;
  logic        progEnPrev, modePrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceLoad  <= '0;
      progCount  <= '0;
      progEnPrev <= 1'b0;
      modePrev   <= 1'b0;
    end else begin
      progEnPrev <= strobes.progEn;
      modePrev   <= strobes.statusMode;
      if (strobes.loadByte)    sinceLoad <= '0;
      else if (sinceLoad != '1) sinceLoad <= sinceLoad + 1'b1;
      if (strobes.progEn && !progEnPrev) progCount <= 16'd1;
      else if (progCount != '1)          progCount <= progCount + 1'b1;
    end
  end

  // R2: no drive unless a read cycle is on the pins
  p_hiz_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN || !weN) |-> !dataOutEn);

  // R8: commit walk starts exactly one window after the last load
  p_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.progEn) |-> (sinceLoad == 16'(WINDOW_CYCLES)));

  // R12: programming ends after the full busy length
  p_prog_len_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearPage |-> (progCount == 16'(PROG_LEN - 1)));

  // R10: bit 6 flips on a status read start
  p_toggle_flip_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readStart && strobes.statusMode && modePrev) |=>
      (dataOut[6] != $past(dataOut[6])));

  // R10: bit 6 holds without a read start
  p_toggle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.readStart && strobes.statusMode && modePrev) |=> $stable(dataOut[6]));

  // R9: low status bits are zero
  p_status_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modePrev && strobes.statusMode) |-> (dataOut[5:0] == 6'd0));

endmodule

bind pagewrite_eeprom pagewrite_eeprom_chk #(
  .PAGE_W(PAGE_W), .WINDOW_CYCLES(WINDOW_CYCLES), .BUSY_CYCLES(BUSY_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
  .dataOut(dataOut), .dataOutEn(dataOutEn), .strobes(strobes)
);

// File: tb/pagewrite_eeprom_test.sv
`timescale 1ns/1ps
module pagewrite_eeprom_test;
  localparam int AW       = 11;
  localparam int PW       = 7;
  localparam int WIN      = 6;
  localparam int BUSY     = 140;
  localparam int PROG_LEN = 140;   // max(BUSY, 2**PW)

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = '0;
  logic [7:0]    dataOut;
  logic          dataOutEn;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  pagewrite_eeprom #(
    .ADDR_W(AW), .PAGE_W(PW), .WINDOW_CYCLES(WIN), .BUSY_CYCLES(BUSY)
  ) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  // single-byte writes: {address, data}
  localparam logic [18:0] VEC [6] = '{
    {11'h000, 8'h3C}, {11'h07F, 8'hC3}, {11'h100, 8'h80},
    {11'h2AA, 8'h7F}, {11'h5FF, 8'hFF}, {11'h7FE, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks are entered at a falling edge
  task automatic doWrite(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; dataIn = d; ceN = 1'b0; oeN = 1'b1; weN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [7:0] d);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    @(negedge clk);
    d = dataOut;
    check("R2 drive on read", {7'd0, dataOutEn}, 8'd1);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitDone();
    repeat (WIN + PROG_LEN + 4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] r0, r1;
    repeat (3) @(negedge clk);
    check("R1 reset dataOut", dataOut, 8'h00);
    check("R2 reset no drive", {7'd0, dataOutEn}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: pin combinations that must not drive
    ceN = 1'b1; oeN = 1'b0; weN = 1'b1; #1;
    check("R2 ce high", {7'd0, dataOutEn}, 8'd0);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b0; #1;
    check("R2 we low", {7'd0, dataOutEn}, 8'd0);
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
    @(negedge clk);

    // table walk: R4, R9, R10, R3
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = VEC[i][18:8];
      d = VEC[i][7:0];
      doWrite(a, d);
      doRead(a, r0);
      doRead(a, r1);
      check("R9 status bit7", {r0[7], 7'd0}, {~d[7], 7'd0});
      check("R9 status low bits", {2'b00, r0[5:0]}, 8'h00);
      check("R10 bit6 toggles", {7'd0, r1[6]}, {7'd0, ~r0[6]});
      waitDone();
      doRead(a, r0);
      check("R4 R3 readback", r0, d);
    end

    // R4: overwrite without erase
    doWrite(11'h000, 8'hC5);
    waitDone();
    doRead(11'h000, r0);
    check("R4 overwrite", r0, 8'hC5);

    // R5: full page 3
    for (int k = 0; k < 128; k++) doWrite(AW'(11'h180 + k), 8'(k) ^ 8'h5C);
    waitDone();
    for (int k = 0; k < 128; k++) begin
      doRead(AW'(11'h180 + k), r0);
      check("R5 full page", r0, 8'(k) ^ 8'h5C);
    end

    // R6 and R13: partial page, offset 1 written twice
    doWrite(11'h180, 8'hE1);
    doWrite(11'h181, 8'hE2);
    doWrite(11'h181, 8'hE7);
    waitDone();
    doRead(11'h180, r0); check("R6 loaded byte", r0, 8'hE1);
    doRead(11'h181, r0); check("R13 last write wins", r0, 8'hE7);
    doRead(11'h182, r0); check("R6 neighbour kept", r0, 8'h5E);
    doRead(11'h1FF, r0); check("R6 far byte kept", r0, 8'h23);

    // R7: foreign-page strobe while page 2 open
    doWrite(11'h104, 8'h9D);
    doWrite(11'h07F, 8'h11);
    waitDone();
    doRead(11'h07F, r0); check("R7 foreign page discarded", r0, 8'hC3);
    doRead(11'h104, r0); check("R7 open page stored", r0, 8'h9D);

    // R8, R11, R12: window boundary and busy length
    doWrite(11'h202, 8'h99);
    waitDone();
    doWrite(11'h200, 8'h41);
    repeat (WIN - 2) @(negedge clk);
    doWrite(11'h201, 8'h42);          // strobe exactly WIN clocks later
    repeat (WIN + 1) @(negedge clk);
    doWrite(11'h202, 8'h43);          // lands in programming
    repeat (PROG_LEN - 5) @(negedge clk);
    doRead(11'h200, r0);              // last busy edge
    check("R12 status on last busy edge", {r0[7], 7'd0}, 8'h80);
    doRead(11'h200, r0);
    check("R12 data after busy", r0, 8'h41);
    doRead(11'h201, r0); check("R8 boundary write accepted", r0, 8'h42);
    doRead(11'h202, r0); check("R11 busy write ignored", r0, 8'h99);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule